// File: doc/BRIEF.md
# Event interrupt register block

This block gathers thirteen peripheral event lines into one interrupt request. Each line has one sticky status bit, which is set on the rising edge of its event. Each line also has one mask bit that decides whether its status bit reaches the interrupt request. Software changes the mask only through two write ports. One port sets every mask bit written as 1 and the other clears every mask bit written as 1. The mask itself can be read but not written. Status bits are cleared by writing ones to the status word.

The event lines come from outside the block, in this bit order:

| Bit | Event |
|-----|-------|
| 0 | receive watermark reached |
| 1 | receive queue empty |
| 2 | receive queue full |
| 3 | transmit queue empty |
| 4 | transmit queue full |
| 5 | receive overrun |
| 6 | framing error |
| 7 | parity error |
| 8 | receive timeout |
| 9 | modem line change |
| 10 | transmit watermark |
| 11 | transmit nearly full |
| 12 | transmit overrun |

Bit 0 is raised when the receive queue fill level reaches its programmed watermark.

The bus is a single-cycle write strobe with address and data, plus a combinational read data port that decodes the same address.

Word addresses:

| Address | Access | Function |
|---------|--------|----------|
| 0 | write | set mask bits |
| 1 | write | clear mask bits |
| 2 | read | mask |
| 3 | read and write | status; writing ones clears bits |

Top module: `irq_regs`

## Requirements
- R1: After reset the mask and status words read as zero and irq is low.
- R2: A write to address 0 sets each mask bit whose data bit is 1. Mask bits written with 0 keep their value.
- R3: A write to address 1 clears each mask bit whose data bit is 1. Mask bits written with 0 keep their value.
- R4: The mask is read-only. A write to address 2, or to any address above 3, changes neither the mask nor the status. Reads of addresses 0, 1 and above 3 return zero.
- R5: A status bit is set in the cycle after its event input rises (a 0 to 1 change between clock edges), whether or not the bit is masked. An event held high does not set the bit again after it has been cleared.
- R6: A write to address 3 clears each status bit whose data bit is 1. Status bits written with 0 are unchanged.
- R7: If an event rises in the same cycle as a write to address 3 that clears that bit, the bit is set after the edge.
- R8: irq is high exactly when some bit is set in both the status word and the mask.
- R9: Read data bits 31 down to 13 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | write strobe |
| addr | input | 4 | word address for both read and write |
| wdata | input | 32 | write data |
| events | input | 13 | event lines, bit order as listed above |
| rdata | output | 32 | read data for addr |
| irq | output | 1 | interrupt request |

## Verification
Two functions can fall in the same cycle: the rising edge of an event and a write-one clear of the same status bit. The bench provokes this for single bits and inside a long stimulus sequence, where event patterns change in the same cycles as writes to every address. A model in the bench applies the clear first and then the edge. After every step it compares the mask, the status word and irq with that model, so a design that lets the clear win is caught.

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int NSRC = 13,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] events,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  localparam logic [AW-1:0] A_SET  = AW'(0);
  localparam logic [AW-1:0] A_CLR  = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);

  logic [NSRC-1:0] mask_q, stat_q, ev_q, rise, wbits;
  logic            w_set, w_clr, w_stat;

  assign wbits  = wdata[NSRC-1:0];
  assign w_set  = wr_en && (addr == A_SET);
  assign w_clr  = wr_en && (addr == A_CLR);
  assign w_stat = wr_en && (addr == A_STAT);
  assign rise   = events & ~ev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
      ev_q   <= '0;
    end else begin
      ev_q <= events;
      if (w_set) mask_q <= mask_q | wbits;
      else if (w_clr) mask_q <= mask_q & ~wbits;
      stat_q <= (stat_q & ~(w_stat ? wbits : '0)) | rise;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_MASK:  rdata[NSRC-1:0] = mask_q;
      A_STAT:  rdata[NSRC-1:0] = stat_q;
      default: rdata = '0;
    endcase
  end

  assign irq = |(stat_q & mask_q);

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> ((mask_q & $past(wbits)) == $past(wbits)) && ((mask_q & $past(mask_q)) == $past(mask_q)));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> ((mask_q & $past(wbits)) == '0) && ((mask_q & ~$past(mask_q)) == '0));

  p_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_set || w_clr) |=> $stable(mask_q));

  p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((stat_q & $past(rise)) == $past(rise)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !w_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && |(rise & wbits)) |=> ((stat_q & $past(rise & wbits)) == $past(rise & wbits)));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0) && (stat_q != '0));

  p_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NSRC] == '0);
endmodule

// File: tb/irq_regs_bench.sv
`timescale 1ns/1ps
module irq_regs_bench;
  localparam int N = 13;
  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [N-1:0] events = 0;
  logic [N-1:0] m_mask = 0, m_stat = 0, m_evq = 0;
  int total = 0, bad = 0;
  bit done = 0;

  irq_regs u_irq_regs (.clk, .rst_n, .wr_en, .addr, .wdata, .events, .rdata, .irq);

  always #4 clk = ~clk;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic observe(input string tag);
    addr = 4'd2; #1 chk(rdata, {19'b0, m_mask}, {tag, " R2 R3 R9 mask"});
    addr = 4'd3; #1 chk(rdata, {19'b0, m_stat}, {tag, " R5 R6 R9 status"});
    chk({31'b0, irq}, {31'b0, |(m_mask & m_stat)}, {tag, " R8 irq"});
  endtask

  task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d,
                      input logic [N-1:0] ev, input string tag);
    logic [N-1:0] r;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; events = ev;
    @(negedge clk);
    wr_en = 0;
    r = ev & ~m_evq;
    m_evq = ev;
    if (we && a == 4'd0) m_mask = m_mask | d[N-1:0];
    if (we && a == 4'd1) m_mask = m_mask & ~d[N-1:0];
    if (we && a == 4'd3) m_stat = m_stat & ~d[N-1:0];
    m_stat = m_stat | r;
    observe(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    observe("R1 reset");
    for (int a = 0; a < 16; a++) begin
      if (a == 2 || a == 3) continue;
      addr = 4'(a); #1 chk(rdata, 32'h0, "R4 unmapped read");
    end
    for (int i = 0; i < N; i++) begin
      step(1, 4'd2, 32'hFFFF_FFFF, '0, "R4 write to mask address");
      step(0, 4'd0, 0, N'(1) << i, "R5 unmasked event latches");
      step(1, 4'd0, 32'(1) << i, N'(1) << i, "R2 set mask bit");
      step(1, 4'd0, 32'h0, N'(1) << i, "R2 zero write keeps mask");
      step(1, 4'd3, 32'h0, N'(1) << i, "R6 zero write keeps status");
      step(1, 4'd3, 32'(1) << i, N'(1) << i, "R6 clear status");
      step(0, 4'd0, 0, N'(1) << i, "R5 held event no relatch");
      step(0, 4'd0, 0, '0, "R5 event falls");
      step(1, 4'd3, 32'(1) << i, N'(1) << i, "R7 edge beats clear");
      addr = 4'd3; #1 chk(rdata, 32'(1) << i, "R7 bit stays set");
      step(1, 4'd7, 32'hFFFF_FFFF, '0, "R4 write above map");
      step(1, 4'd1, 32'(1) << i, '0, "R3 clear mask bit");
      step(1, 4'd3, 32'hFFFF_FFFF, '0, "R6 clear all");
    end
    step(1, 4'd0, 32'hFFFF_FFFF, '0, "R2 set all");
    step(1, 4'd1, 32'h0000_0AAA, '1, "R3 partial clear");
    step(1, 4'd3, 32'h0000_1555, '1, "R6 partial clear");
    for (int k = 0; k < 400; k++) begin
      logic [31:0] d;
      logic [N-1:0] ev;
      d  = (32'(k) * 32'h9E37_79B1) ^ (32'(k) << 7);
      ev = N'((k * 37 + 11) * 613);
      step((k % 3) != 2, 4'(k % 5), d, ev, "R7 sweep");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule